// File: doc/BRIEF.md
# ADC Sample Vector Ring Writer

This block turns each parallel sample vector from a bank of ADC channels into one fixed 128-byte record and streams that record, one memory word at a time, into a circular buffer held in a large external memory. A record contains the signed sample of every channel, a 64-bit timestamp and the state of the digital input lines. Bytes that carry no field are written as zero. The timestamp is a free-running clock-cycle counter, captured in the cycle the vector is taken.

The buffer runs freely with no trigger. Every record lands at the current write offset. The offset then moves on by one record and wraps to the start of the region when it reaches the end. The address of the next record slot is always visible on `next_addr`, so software can find the newest data: it lies just below that address, or just below the region end after a wrap. The memory side is a plain word-write port (address, data, valid, ready). While that port stalls, the block keeps the record it is sending and drops any new vector. A dropped vector sets a sticky overflow flag.

The control is a two-state machine. ST_IDLE waits for a vector. The transition "capture" (ST_IDLE to ST_EMIT on `vec_valid`) latches the packed record and clears the word index. In ST_EMIT the transition "beat" (ST_EMIT to ST_EMIT on an accepted word that is not the last) moves the word index on. The transition "retire" (ST_EMIT to ST_IDLE on the accepted last word) advances the write offset by one record.

Top module: `ringw_writer`

## Requirements
- R1: After reset `next_addr` equals the region base (0x80000000 by default), `mem_valid` is low, `overflow` is low, and the timestamp counter restarts from 0.
- R2: Each accepted vector produces exactly 16 word writes of 64 bits. The first goes to `next_addr` and each following word goes 8 bytes higher.
- R3: Within a record, the 16-bit sample of channel n (n = 0..39) is at byte 2n, little-endian. Record byte b lands in bits [8*(b mod 8)+7 : 8*(b mod 8)] of word b/8, so channel n is in bits [16*(n mod 4)+15 : 16*(n mod 4)] of word n/4.
- R4: Bytes 0x50..0x57 (word 10) hold the timestamp. The timestamp is 0 in the first cycle after reset, rises by 1 every clock, and the value stored is the one present in the cycle the vector is accepted.
- R5: Byte 0x58 (bits [7:0] of word 11) holds the 8 line states. Bytes 0x59..0x7F (the rest of word 11 and words 12..15) are written as zero.
- R6: `next_addr` rises by 128 when the last word of a record is accepted and changes at no other time.
- R7: The write offset wraps modulo the region size (a parameter, 2 GiB by default). After the last record slot, `next_addr` returns to the base, and every write address stays inside the region.
- R8: While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values until the word is accepted.
- R9: A vector is taken only in ST_IDLE. A vector that arrives while a record is being written, including the cycle of its last word, is dropped and writes nothing. It sets `overflow`, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vec_valid | input | 1 | A sample vector is present this cycle |
| vec_samples | input | NUM_CH*SAMPLE_W | Packed channel samples, channel n at bits [16n+15:16n] |
| vec_lines | input | LINES_W | Digital line states belonging to the vector |
| mem_valid | output | 1 | A record word is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered word |
| mem_addr | output | ADDR_W | Byte address of the offered word |
| mem_data | output | WORD_W | Offered record word |
| next_addr | output | ADDR_W | Byte address where the next record will be written |
| overflow | output | 1 | Sticky: a vector was dropped while busy |

## Verification
The bench runs with a four-slot region, so wraparound comes quickly. It checks that the fourth record returns `next_addr` to the base and that the fifth record overwrites slot 0. A pointer that saturated or ran past the region would put that record in the wrong slot or report the wrong address. It also holds `mem_ready` low for several cycles and then toggles it. A design that moved on while stalled would skip or duplicate words, and the stored record would differ from the expected one. Memory is pre-filled with a non-zero pattern, so a design that left unused bytes unwritten would fail the zero checks. A second vector is pushed in while a record is in flight. A design that accepted it would corrupt the record, add extra writes or advance the pointer twice, and one that failed to keep the overflow flag would lose it on the next clean record.

// File: rtl/ringw_pkg.sv
package ringw_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } wr_state_t;

endpackage

// File: rtl/ringw_stamp.sv
module ringw_stamp #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] stamp
);

    always_ff @(posedge clk) begin
        if (rst) stamp <= '0;
        else     stamp <= stamp + TS_W'(1);
    end

    // R4: the counter advances by exactly one per clock
    assert_tick_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stamp == $past(stamp) + TS_W'(1));

endmodule

// File: rtl/ringw_ptr.sv
module ringw_ptr #(
    parameter int REGION_LOG2 = 31,
    parameter int REC_BYTES   = 128
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   advance,
    output logic [REGION_LOG2-1:0] offset
);

    localparam logic [REGION_LOG2-1:0] STEP = REGION_LOG2'(REC_BYTES);

    always_ff @(posedge clk) begin
        if (rst)          offset <= '0;
        else if (advance) offset <= offset + STEP;
    end

    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        advance |=> offset == $past(offset) + STEP);

    assert_still_R6: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(offset));

endmodule

// File: rtl/ringw_pack.sv
module ringw_pack #(
    parameter int NUM_CH     = 40,
    parameter int SAMPLE_W   = 16,
    parameter int TS_W       = 64,
    parameter int LINES_W    = 8,
    parameter int REC_BYTES  = 128,
    parameter int TS_BYTE    = 80,
    parameter int LINES_BYTE = 88
) (
    input  logic [NUM_CH*SAMPLE_W-1:0] samples,
    input  logic [TS_W-1:0]            stamp,
    input  logic [LINES_W-1:0]         lines,
    output logic [REC_BYTES*8-1:0]     rec
);

    localparam int SAMP_BITS = NUM_CH * SAMPLE_W;

    always_comb begin
        rec = '0;
        rec[0 +: SAMP_BITS]           = samples;
        rec[TS_BYTE*8 +: TS_W]        = stamp;
        rec[LINES_BYTE*8 +: LINES_W]  = lines;
    end

endmodule

// File: rtl/ringw_writer.sv
module ringw_writer
    import ringw_pkg::*;
#(
    parameter int              NUM_CH      = 40,
    parameter int              SAMPLE_W    = 16,
    parameter int              TS_W        = 64,
    parameter int              LINES_W     = 8,
    parameter int              WORD_W      = 64,
    parameter int              REC_BYTES   = 128,
    parameter int              TS_BYTE     = 80,
    parameter int              LINES_BYTE  = 88,
    parameter int              ADDR_W      = 32,
    parameter int              REGION_LOG2 = 31,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h8000_0000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       vec_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] vec_samples,
    input  logic [LINES_W-1:0]         vec_lines,
    output logic                       mem_valid,
    input  logic                       mem_ready,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [WORD_W-1:0]          mem_data,
    output logic [ADDR_W-1:0]          next_addr,
    output logic                       overflow
);

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WORDS      = REC_BYTES / WORD_BYTES;
    localparam int WIDX_W     = $clog2(WORDS);
    localparam int REC_BITS   = REC_BYTES * 8;
    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(WORDS - 1);
    localparam logic [ADDR_W:0]   REGION_TOP =
        (ADDR_W+1)'(REGION_BASE) + ((ADDR_W+1)'(1) << REGION_LOG2);

    wr_state_t               state_q, state_d;
    logic [WIDX_W-1:0]       word_idx;
    logic [REC_BITS-1:0]     rec_d, rec_q;
    logic [TS_W-1:0]         stamp;
    logic [REGION_LOG2-1:0]  offset;
    logic                    capture, beat, last_word, advance, drop;

    ringw_stamp #(.TS_W(TS_W)) u_stamp (
        .clk   (clk),
        .rst   (rst),
        .stamp (stamp)
    );

    ringw_pack #(
        .NUM_CH     (NUM_CH),
        .SAMPLE_W   (SAMPLE_W),
        .TS_W       (TS_W),
        .LINES_W    (LINES_W),
        .REC_BYTES  (REC_BYTES),
        .TS_BYTE    (TS_BYTE),
        .LINES_BYTE (LINES_BYTE)
    ) u_pack (
        .samples (vec_samples),
        .stamp   (stamp),
        .lines   (vec_lines),
        .rec     (rec_d)
    );

    ringw_ptr #(
        .REGION_LOG2 (REGION_LOG2),
        .REC_BYTES   (REC_BYTES)
    ) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .offset  (offset)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions: capture, beat, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (vec_valid)              state_d = ST_EMIT;
            ST_EMIT: if (mem_ready && last_word) state_d = ST_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        mem_valid = (state_q == ST_EMIT);
        last_word = (word_idx == LAST_IDX);
        capture   = (state_q == ST_IDLE) && vec_valid;
        beat      = mem_valid && mem_ready;
        advance   = beat && last_word;
        drop      = (state_q == ST_EMIT) && vec_valid;
        mem_data  = rec_q[int'(word_idx)*WORD_W +: WORD_W];
        mem_addr  = REGION_BASE + ADDR_W'(offset)
                  + ADDR_W'(word_idx) * ADDR_W'(WORD_BYTES);
        next_addr = REGION_BASE + ADDR_W'(offset);
    end

    // record holding, word index and overflow flag
    always_ff @(posedge clk) begin
        if (rst) begin
            word_idx <= '0;
            rec_q    <= '0;
            overflow <= 1'b0;
        end else begin
            if (capture) begin
                rec_q    <= rec_d;
                word_idx <= '0;
            end else if (beat) begin
                word_idx <= last_word ? '0 : word_idx + WIDX_W'(1);
            end
            if (drop) overflow <= 1'b1;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    assert_word_step_R2: assert property (@(posedge clk) disable iff (rst)
        beat && !last_word |=> mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES));

    assert_in_region_R7: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_addr >= REGION_BASE && {1'b0, mem_addr} < REGION_TOP);

    assert_drop_R9: assert property (@(posedge clk) disable iff (rst)
        drop |=> overflow);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

// File: tb/test_ringw_writer.sv
`timescale 1ns/1ps
module test_ringw_writer;

    localparam int          NCH  = 40;
    localparam int          RLOG = 9;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              vec_valid = 1'b0;
    logic [NCH*16-1:0] vec_samples = '0;
    logic [7:0]        vec_lines = '0;
    logic              mem_valid;
    logic              mem_ready = 1'b1;
    logic [31:0]       mem_addr;
    logic [63:0]       mem_data;
    logic [31:0]       next_addr;
    logic              overflow;

    int total = 0;
    int bad   = 0;
    longint unsigned cyc = 0;
    int beats = 0;
    int wd = 0;
    logic [63:0] mem [64];

    always #2.5 clk = ~clk;

    ringw_writer #(.REGION_LOG2(RLOG), .REGION_BASE(BASE)) i_ringw_writer (
        .clk(clk), .rst(rst), .vec_valid(vec_valid), .vec_samples(vec_samples),
        .vec_lines(vec_lines), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .next_addr(next_addr),
        .overflow(overflow)
    );

    // memory model and cycle count
    always @(posedge clk) begin
        if (rst) begin
            cyc   <= 0;
            beats <= 0;
            for (int i = 0; i < 64; i++) mem[i] <= 64'hA5A5_A5A5_A5A5_A5A5;
        end else begin
            cyc <= cyc + 1;
            if (mem_valid && mem_ready) begin
                mem[6'((mem_addr - BASE) >> 3)] <= mem_data;
                beats <= beats + 1;
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 20000) begin
            bad++; total++;
            $display("FAIL R2 watchdog: cycles=%0d expected < %0d", wd, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] samp(int seed, int n);
        return 16'(seed * 1843 + n * 291 + 32769);
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_vec(int seed, logic [7:0] lines, output longint unsigned ts);
        @(negedge clk);
        for (int n = 0; n < NCH; n++) vec_samples[n*16 +: 16] = samp(seed, n);
        vec_lines = lines;
        vec_valid = 1'b1;
        ts = cyc;
        @(negedge clk);
        vec_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (mem_valid) @(negedge clk);
    endtask

    task automatic check_slot(int slot, int seed, logic [7:0] lines, longint unsigned ts);
        logic [1023:0] e;
        e = '0;
        for (int n = 0; n < NCH; n++) e[n*16 +: 16] = samp(seed, n);
        e[640 +: 64] = 64'(ts);
        e[704 +: 8]  = lines;
        for (int k = 0; k < 16; k++) begin
            if (k < 10)       check("R3", $sformatf("slot%0d word%0d", slot, k), mem[slot*16+k], e[k*64 +: 64]);
            else if (k == 10) check("R4", $sformatf("slot%0d timestamp", slot), mem[slot*16+k], e[k*64 +: 64]);
            else              check("R5", $sformatf("slot%0d word%0d", slot, k), mem[slot*16+k], e[k*64 +: 64]);
        end
    endtask

    task automatic t_reset();
        check("R1", "next_addr", 64'(next_addr), 64'(BASE));
        check("R1", "mem_valid", 64'(mem_valid), 64'd0);
        check("R1", "overflow", 64'(overflow), 64'd0);
    endtask

    task automatic t_basic();
        longint unsigned ts;
        int b0;
        b0 = beats;
        send_vec(1, 8'h5C, ts);
        wait_idle();
        check("R2", "beats per record", 64'(beats - b0), 64'd16);
        check_slot(0, 1, 8'h5C, ts);
        check("R6", "next_addr after one", 64'(next_addr), 64'(BASE + 128));
    endtask

    task automatic t_stall();
        longint unsigned ts;
        int b0;
        mem_ready = 1'b0;
        b0 = beats;
        send_vec(2, 8'hA3, ts);
        repeat (4) @(negedge clk);
        check("R8", "valid held", 64'(mem_valid), 64'd1);
        check("R8", "addr held", 64'(mem_addr), 64'(BASE + 128));
        check("R8", "no beats while stalled", 64'(beats - b0), 64'd0);
        check("R6", "next_addr still", 64'(next_addr), 64'(BASE + 128));
        while (mem_valid) begin
            mem_ready = ~mem_ready;
            @(negedge clk);
        end
        mem_ready = 1'b1;
        check("R2", "beats under stall", 64'(beats - b0), 64'd16);
        check_slot(1, 2, 8'hA3, ts);
        check("R9", "no overflow yet", 64'(overflow), 64'd0);
    endtask

    task automatic t_overflow();
        longint unsigned ts, tsx;
        int b0;
        b0 = beats;
        send_vec(3, 8'h01, ts);
        send_vec(99, 8'hFF, tsx);
        wait_idle();
        check("R9", "overflow set", 64'(overflow), 64'd1);
        check("R9", "dropped vector not written", 64'(beats - b0), 64'd16);
        check("R6", "single advance", 64'(next_addr), 64'(BASE + 384));
        check_slot(2, 3, 8'h01, ts);
    endtask

    task automatic t_wrap();
        longint unsigned ts;
        send_vec(4, 8'h80, ts);
        wait_idle();
        check_slot(3, 4, 8'h80, ts);
        check("R7", "wrap to base", 64'(next_addr), 64'(BASE));
        check("R9", "overflow sticky", 64'(overflow), 64'd1);
        send_vec(5, 8'h3E, ts);
        wait_idle();
        check_slot(0, 5, 8'h3E, ts);
        check("R7", "after wrap", 64'(next_addr), 64'(BASE + 128));
        check_slot(1, 2, 8'hA3, 0 + 0 * 0 + mem[1*16+10]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stall();
        t_overflow();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule